// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a 16-bit, word-addressed processor and works out the address of the next instruction every cycle. Sequential flow adds one to the counter. The decoder supplies its branch and jump controls, the 6-bit immediate, the 12-bit jump field and the register values to compare. From these the block forms the next address.

Control transfers here do not add an offset to the counter. A taken branch keeps the counter's upper 10 bits and puts the immediate in place of its low 6 bits. A direct jump keeps the upper 4 bits and puts the 12-bit field in place of the low 12 bits. A jump through a register loads a full 16-bit value. The block also presents the return address, which is the current counter plus one, for the link register write of a jump-and-link.

The reset input is active low. Asserting it clears the counter at once. Its release passes through a two-stage synchronizer before the counter is allowed to advance.

Top module: `next_pc_unit`

## Requirements
- R1: Driving `rst_n` low clears `pc` to 0x0000 without waiting for a clock edge. After `rst_n` returns high, `pc` stays 0x0000 across the first two rising edges and becomes 0x0001 on the third when no control is active.
- R2: With all five control inputs low, `next_pc` equals `pc + 1`, and 0xFFFF wraps to 0x0000.
- R3: When `is_beq` is high and `cmp_a == cmp_b`, `next_pc` is `{pc[15:6], imm6}`.
- R4: When `is_beq` is high and `cmp_a != cmp_b`, with no jump active, `next_pc` equals `pc + 1`.
- R5: When `is_beqz` is high, the branch is taken exactly when `cmp_a` is zero, whatever `cmp_b` holds. The target is `{pc[15:6], imm6}`. Otherwise `next_pc` is `pc + 1`.
- R6: When `is_j` or `is_jal` is high and `is_jr` is low, `next_pc` is `{pc[15:12], jaddr}`.
- R7: `link_value` equals `pc + 1` (16-bit wrap) in every cycle out of reset. This is the value a jump-and-link writes to register 7.
- R8: When `is_jr` is high, `next_pc` equals `jr_value`.
- R9: The target sources rank in this order: register jump first, then the direct jumps, then a taken branch, then the increment.
- R10: On each rising clock edge out of reset, `pc` takes the value `next_pc` held just before that edge.
- R11: The kept upper bits of branch and jump targets come from the current `pc`, not from `pc + 1`. For example, a branch at 0x003F with immediate 0x01 goes to 0x0001, and a jump at 0x0FFF with field 0x456 goes to 0x0456.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| is_beq | input | 1 | Decoded branch-if-equal |
| is_beqz | input | 1 | Decoded branch-if-zero |
| is_j | input | 1 | Decoded direct jump |
| is_jal | input | 1 | Decoded jump-and-link |
| is_jr | input | 1 | Decoded jump through register |
| imm6 | input | 6 | Branch immediate, becomes the low target bits |
| jaddr | input | 12 | Jump address field, becomes the low target bits |
| jr_value | input | 16 | Register value for the register jump |
| cmp_a | input | 16 | First compared register value |
| cmp_b | input | 16 | Second compared register value (equal-branch only) |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Address loaded at the next edge |
| link_value | output | 16 | Return address, pc + 1 |

## Verification
The assertions check on every clock the register load of `next_pc`, the increment and its wrap when no control is active, the register-jump and direct-jump targets and their precedence, the branch-if-zero decision, and the link value. Only the bench scenarios can show certain behaviours. These are the asynchronous clearing of the counter and its two-edge release delay, the page-boundary cases where `pc + 1` would change the kept upper bits, and a branch-if-equal with unequal operands falling through.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Decoded control-transfer selects, one bit per instruction class
  typedef struct packed {
    logic jr;
    logic jal;
    logic j;
    logic beqz;
    logic beq;
  } npc_ctrl_t;

  // Which source fed the next address
  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_BR   = 3'd1,
    SRC_JMP  = 3'd2,
    SRC_REG  = 3'd3
  } npc_src_e;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/npc_branch_eval.sv
module npc_branch_eval #(
  parameter int DATA_W = 16
) (
  input  logic              is_beq,
  input  logic              is_beqz,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output logic              taken
);

  logic eq_hit;
  logic zero_hit;

  always_comb begin
    eq_hit   = is_beq  && (cmp_a == cmp_b);
    zero_hit = is_beqz && (cmp_a == '0);
    taken    = eq_hit || zero_hit;
  end

endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
  import npc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BR_W   = 6,
  parameter int JMP_W  = 12
) (
  input  npc_ctrl_t         ctrl,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] pc_inc,
  input  logic [BR_W-1:0]   imm,
  input  logic [JMP_W-1:0]  jaddr,
  input  logic [ADDR_W-1:0] jr_value,
  output npc_src_e          src,
  output logic [ADDR_W-1:0] next_pc
);

  localparam int BR_KEEP  = ADDR_W - BR_W;
  localparam int JMP_KEEP = ADDR_W - JMP_W;

  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] jmp_target;

  // Page-style targets keep the upper bits of the current pc
  always_comb begin
    br_target  = {pc[ADDR_W-1 -: BR_KEEP],  imm};
    jmp_target = {pc[ADDR_W-1 -: JMP_KEEP], jaddr};
  end

  always_comb begin
    if (ctrl.jr) begin
      src = SRC_REG;
    end else if (ctrl.j || ctrl.jal) begin
      src = SRC_JMP;
    end else if (br_taken) begin
      src = SRC_BR;
    end else begin
      src = SRC_INC;
    end
  end

  always_comb begin
    unique case (src)
      SRC_REG: next_pc = jr_value;
      SRC_JMP: next_pc = jmp_target;
      SRC_BR:  next_pc = br_target;
      default: next_pc = pc_inc;
    endcase
  end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  logic [ADDR_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_en)) |-> (q == $past(d)));

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BR_W   = 6,
  parameter int JMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_beq,
  input  logic              is_beqz,
  input  logic              is_j,
  input  logic              is_jal,
  input  logic              is_jr,
  input  logic [BR_W-1:0]   imm6,
  input  logic [JMP_W-1:0]  jaddr,
  input  logic [ADDR_W-1:0] jr_value,
  input  logic [ADDR_W-1:0] cmp_a,
  input  logic [ADDR_W-1:0] cmp_b,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] link_value
);

  localparam int JMP_KEEP = ADDR_W - JMP_W;
  localparam int BR_KEEP  = ADDR_W - BR_W;

  logic              rst_sync_n;
  logic              br_taken;
  logic [ADDR_W-1:0] pc_inc;
  npc_ctrl_t         ctrl;
  npc_src_e          src;

  always_comb begin
    ctrl.jr   = is_jr;
    ctrl.jal  = is_jal;
    ctrl.j    = is_j;
    ctrl.beqz = is_beqz;
    ctrl.beq  = is_beq;
    pc_inc    = pc + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  assign link_value = pc_inc;

  npc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_branch_eval #(.DATA_W(ADDR_W)) br_eval_i (
    .is_beq  (is_beq),
    .is_beqz (is_beqz),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .taken   (br_taken)
  );

  npc_target_sel #(
    .ADDR_W (ADDR_W),
    .BR_W   (BR_W),
    .JMP_W  (JMP_W)
  ) tgt_sel_i (
    .ctrl     (ctrl),
    .br_taken (br_taken),
    .pc       (pc),
    .pc_inc   (pc_inc),
    .imm      (imm6),
    .jaddr    (jaddr),
    .jr_value (jr_value),
    .src      (src),
    .next_pc  (next_pc)
  );

  npc_pc_reg #(.ADDR_W(ADDR_W)) pc_reg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (1'b1),
    .d       (next_pc),
    .q       (pc)
  );

  // R2
  seq_incr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(is_jr || is_j || is_jal || is_beq || is_beqz) |-> (next_pc == pc + 1'b1));

  // R8
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_jr |-> (next_pc == jr_value));

  // R6
  direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!is_jr && (is_j || is_jal)) |-> (next_pc == {pc[ADDR_W-1 -: JMP_KEEP], jaddr}));

  // R5
  zero_branch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_beqz && !is_beq && !is_jr && !is_j && !is_jal) |->
      (next_pc == ((cmp_a == '0) ? {pc[ADDR_W-1 -: BR_KEEP], imm6} : pc + 1'b1)));

  // R7
  link_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (link_value - pc) == {{(ADDR_W-1){1'b0}}, 1'b1});

  // R9
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_jr && (src != SRC_REG)) == 1'b0);

endmodule

// File: tb/next_pc_unit_tb.sv
module next_pc_unit_tb_top;

  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        is_beq, is_beqz, is_j, is_jal, is_jr;
  logic [5:0]  imm6;
  logic [11:0] jaddr;
  logic [15:0] jr_value, cmp_a, cmp_b;
  logic [15:0] pc, next_pc, link_value;

  int errors = 0;
  int checks = 0;

  always #(TCK/2) clk = ~clk;

  next_pc_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .is_beq(is_beq), .is_beqz(is_beqz), .is_j(is_j), .is_jal(is_jal), .is_jr(is_jr),
    .imm6(imm6), .jaddr(jaddr), .jr_value(jr_value),
    .cmp_a(cmp_a), .cmp_b(cmp_b),
    .pc(pc), .next_pc(next_pc), .link_value(link_value)
  );

  // ctrl bit order: {jr, jal, j, beqz, beq}
  typedef struct packed {
    logic [15:0] start;
    logic [4:0]  ctrl;
    logic [5:0]  imm;
    logic [11:0] ja;
    logic [15:0] jrv;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp_next;
    logic [15:0] exp_link;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 5'b00000, 6'h00, 12'h000, 16'h0000, 16'h0000, 16'h0000, 16'h1235, 16'h1235}, // R2
    '{16'hFFFF, 5'b00000, 6'h00, 12'h000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R2 wrap, R7
    '{16'hA5C3, 5'b00001, 6'h15, 12'h000, 16'h0000, 16'h0042, 16'h0042, 16'hA5D5, 16'hA5C4}, // R3
    '{16'hA5C3, 5'b00001, 6'h15, 12'h000, 16'h0000, 16'h0001, 16'h0002, 16'hA5C4, 16'hA5C4}, // R4
    '{16'h7000, 5'b00010, 6'h3F, 12'h000, 16'h0000, 16'h0000, 16'h0055, 16'h703F, 16'h7001}, // R5
    '{16'h7000, 5'b00010, 6'h3F, 12'h000, 16'h0000, 16'h0001, 16'h0000, 16'h7001, 16'h7001}, // R5
    '{16'h3ABC, 5'b00100, 6'h00, 12'h123, 16'h0000, 16'h0000, 16'h0000, 16'h3123, 16'h3ABD}, // R6
    '{16'h3ABC, 5'b01000, 6'h00, 12'hFED, 16'h0000, 16'h0000, 16'h0000, 16'h3FED, 16'h3ABD}, // R6 R7
    '{16'h0FFF, 5'b00100, 6'h00, 12'h456, 16'h0000, 16'h0000, 16'h0000, 16'h0456, 16'h1000}, // R11
    '{16'h003F, 5'b00001, 6'h01, 12'h000, 16'h0000, 16'h0009, 16'h0009, 16'h0001, 16'h0040}, // R11
    '{16'h2222, 5'b10000, 6'h00, 12'h000, 16'hBEEF, 16'h0000, 16'h0000, 16'hBEEF, 16'h2223}, // R8
    '{16'h2222, 5'b10101, 6'h11, 12'h999, 16'h0102, 16'h0003, 16'h0003, 16'h0102, 16'h2223}, // R9
    '{16'h4444, 5'b00101, 6'h02, 12'h777, 16'h0000, 16'h0005, 16'h0005, 16'h4777, 16'h4445}  // R9
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {is_jr, is_jal, is_j, is_beqz, is_beq} = 5'b0;
    imm6 = '0; jaddr = '0; jr_value = '0; cmp_a = '0; cmp_b = '0;
  endtask

  initial begin
    #(TCK * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #(TCK * 3);
    check("R1 reset value", pc, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      // load the start pc through a register jump
      idle_inputs();
      is_jr = 1'b1;
      jr_value = VECS[i].start;
      @(negedge clk);
      check("R10 start load", pc, VECS[i].start);
      {is_jr, is_jal, is_j, is_beqz, is_beq} = VECS[i].ctrl;
      imm6 = VECS[i].imm; jaddr = VECS[i].ja; jr_value = VECS[i].jrv;
      cmp_a = VECS[i].a; cmp_b = VECS[i].b;
      #1;
      check($sformatf("R2-vector%0d next_pc", i), next_pc, VECS[i].exp_next);
      check("R7 link_value", link_value, VECS[i].exp_link);
      @(negedge clk);
      check("R10 pc after edge", pc, VECS[i].exp_next);
    end

    // R1: asynchronous clear mid-run and delayed release
    idle_inputs();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", pc, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 held after edge 1", pc, 16'h0000);
    @(negedge clk);
    check("R1 held after edge 2", pc, 16'h0000);
    @(negedge clk);
    check("R1 advances on edge 3", pc, 16'h0001);

    // R2: several plain increments in a row
    repeat (3) @(negedge clk);
    check("R2 run of increments", pc, 16'h0004);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule